// File: doc/BRIEF.md
# I2C Byte Master

This block is a byte-at-a-time I2C bus master that software drives through five 8-bit registers: own address, clock divider, control, status and data. Software sets the master bit in the control register to put a START on the bus. It then writes the data register to clock out an address or data byte, with 8 bits followed by an acknowledge slot. It can clear the transmit-direction bit and read the data register to clock in bytes. Clearing the master bit ends the transfer with a STOP. A repeated START can be requested ahead of the next transmitted byte.

SCL and SDA are open-drain. The block only pulls a line low (`*_oe` high) and always senses the real line level. This lets it see other masters, slaves that stretch the clock, and a lost arbitration. Receiving is triggered by reads: each read of the data register in receive mode returns the previous byte and starts clocking in the next one, so the first read after turning the bus around is a dummy read. Software picks the acknowledge for each incoming byte in advance. Software also requests the STOP before it reads the final byte, so that no extra byte is clocked.

Top module: `i2c_byte_master`

## Requirements
- R1: Registers are selected by byte address = index << REG_SHIFT, with index 0 own address, 1 divider, 2 control, 3 status, 4 data. An address whose low REG_SHIFT bits are not zero is ignored. Own address, divider and control read back as written; control bits 1..0 read 0.
- R2: With control bit 7 (enable) set, setting control bit 5 (master) while the bus is free produces a START (SDA falls while SCL is high). Status bit 5 (bus busy) is then set. Clearing bit 5 after a byte produces a STOP (SDA rises while SCL is high), and bus busy returns to 0.
- R3: A data-register write in transmit mode (control bit 4 = 1) clocks out the byte MSB first, then releases SDA for a ninth clock. On completion, status bit 7 (transfer complete) and bit 1 (interrupt pending) are set, and status bit 0 holds the ninth-bit level (1 = no acknowledge).
- R4: In receive mode (control bit 4 = 0), a data-register read returns the last received byte and starts reception of the next. The ninth bit the master drives is low (ACK) when control bit 3 is 0, and high (NACK) when it is 1.
- R5: A data-register read made after the master bit has been cleared returns the last byte and clocks no further byte.
- R6: With control bit 2 set while master, the next data-register write is preceded by a repeated START; bit 2 then reads 0.
- R7: A status write clears bit 4 (arbitration lost) and bit 1 (interrupt pending) wherever the written value has a 0, and leaves a flag set where it has a 1. Transfer complete clears when the next byte starts.
- R8: Each bit lasts 2*(divider+1) clock cycles: SCL low for divider+1 cycles, then high for divider+1 cycles. High-phase time only counts while SCL really reads high, so a slave holding SCL low delays completion.
- R9: If SDA reads low at the end of a data-bit high phase while the master sends a 1, status bit 4 and bit 1 are set. The master releases both lines and control bit 5 is cleared.
- R10: While enable is 0 the sequencer is idle, both lines are released and all status flags read 0.
- R11: `irq` is high exactly when interrupt pending is set and control bit 6 (interrupt enable) is 1.
- R12: Bus busy follows START and STOP conditions seen on the lines, including those made by another device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (has effect on the data register) |
| reg_addr | input | REG_SHIFT+3 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with REG_SHIFT = 2, so the spaced address map is used and addresses with low bits set can be shown to be ignored. The divider is mostly 1, which gives 4-cycle bits, so a full write-then-read transaction with repeated START fits in a few hundred cycles. It is switched to 4 once to measure a 10-cycle bit period. The bench's bus model can hold SCL low and can pull SDA low on any bit slot. This exposes clock stretching, arbitration loss and a STOP made by another device.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter int REG_SHIFT = 2,
  localparam int AW = REG_SHIFT + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  input  logic          scl_i,
  output logic          scl_oe,
  input  logic          sda_i,
  output logic          sda_oe
);
  typedef enum logic [3:0] {
    S_IDLE, S_STA, S_HOLD, S_LO, S_HI, S_P1, S_P2, S_P3, S_R1, S_R2, S_R3
  } state_t;

  localparam logic [AW-1:0] LOW_MASK = AW'((1 << REG_SHIFT) - 1);

  state_t     st;
  logic [7:0] own_adr, div, cr, data_r, sh, cnt;
  logic [3:0] bitn;
  logic       txm, pend, scl_o, sda_o, scl_q, sda_q;
  logic       icf, ibb, ial, iif, rxak;

  logic [2:0] idx;
  logic       hit, wr_adr, wr_div, wr_cr, wr_sr, wr_dat, rd_dat;
  logic       en, msta, mtx, txak, rsta, tick, bit_out, start_det, stop_det;

  assign idx    = reg_addr[AW-1:REG_SHIFT];
  assign hit    = (reg_addr & LOW_MASK) == '0;
  assign wr_adr = reg_wr && hit && idx == 3'd0;
  assign wr_div = reg_wr && hit && idx == 3'd1;
  assign wr_cr  = reg_wr && hit && idx == 3'd2;
  assign wr_sr  = reg_wr && hit && idx == 3'd3;
  assign wr_dat = reg_wr && hit && idx == 3'd4;
  assign rd_dat = reg_rd && hit && idx == 3'd4;

  assign en   = cr[7];
  assign msta = cr[5];
  assign mtx  = cr[4];
  assign txak = cr[3];
  assign rsta = cr[2];

  assign tick      = cnt == div;
  assign bit_out   = (bitn == 4'd8) ? (txm | txak) : (!txm | sh[7]);
  assign start_det = scl_q && scl_i && sda_q && !sda_i;
  assign stop_det  = scl_q && scl_i && !sda_q && sda_i;

  assign scl_oe = !scl_o;
  assign sda_oe = !sda_o;
  assign irq    = iif && cr[6];

  always_comb begin
    case (hit ? idx : 3'd7)
      3'd0:    reg_rdata = own_adr;
      3'd1:    reg_rdata = div;
      3'd2:    reg_rdata = cr;
      3'd3:    reg_rdata = {icf, 1'b0, ibb, ial, 2'b00, iif, rxak};
      3'd4:    reg_rdata = data_r;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      own_adr <= '0; div <= '0; cr <= '0; data_r <= '0; sh <= '0; cnt <= '0;
      bitn <= '0; txm <= 1'b0; pend <= 1'b0;
      scl_o <= 1'b1; sda_o <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
      icf <= 1'b0; ibb <= 1'b0; ial <= 1'b0; iif <= 1'b0; rxak <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (wr_adr) own_adr <= reg_wdata;
      if (wr_div) div <= reg_wdata;
      if (wr_cr)  cr <= {reg_wdata[7:2], 2'b00};
      if (wr_dat) data_r <= reg_wdata;

      if (!en) begin
        st <= S_IDLE; scl_o <= 1'b1; sda_o <= 1'b1; cnt <= '0; pend <= 1'b0;
        icf <= 1'b0; ibb <= 1'b0; ial <= 1'b0; iif <= 1'b0; rxak <= 1'b0;
      end else begin
        if (wr_sr) begin
          ial <= ial & reg_wdata[4];
          iif <= iif & reg_wdata[1];
        end
        if (start_det)     ibb <= 1'b1;
        else if (stop_det) ibb <= 1'b0;
        if (wr_dat && mtx && (st == S_STA || st == S_HOLD)) begin
          sh   <= reg_wdata;
          pend <= 1'b1;
        end
        cnt <= tick ? 8'd0 : cnt + 8'd1;

        case (st)
          S_IDLE: begin
            scl_o <= 1'b1; sda_o <= 1'b1; cnt <= '0;
            if (msta && !ibb) begin st <= S_STA; sda_o <= 1'b0; end
          end
          S_STA: if (tick) begin st <= S_HOLD; scl_o <= 1'b0; end
          S_HOLD: begin
            cnt <= '0; sda_o <= 1'b1;
            if (!msta) begin
              st <= S_P1; sda_o <= 1'b0;
            end else if (pend) begin
              pend <= 1'b0; txm <= 1'b1; bitn <= '0; icf <= 1'b0;
              if (rsta) begin st <= S_R1; cr[2] <= 1'b0; end
              else st <= S_LO;
            end else if (rd_dat && !mtx) begin
              txm <= 1'b0; bitn <= '0; icf <= 1'b0; st <= S_LO;
            end
          end
          S_LO: begin
            scl_o <= 1'b0; sda_o <= bit_out;
            if (tick) begin st <= S_HI; scl_o <= 1'b1; end
          end
          S_HI: begin
            if (!scl_i) cnt <= cnt;
            else if (tick) begin
              if (bitn != 4'd8) begin
                if (txm && sh[7] && !sda_i) begin
                  ial <= 1'b1; iif <= 1'b1; cr[5] <= 1'b0;
                  st <= S_IDLE; scl_o <= 1'b1; sda_o <= 1'b1;
                end else begin
                  sh <= {sh[6:0], sda_i}; bitn <= bitn + 4'd1;
                  st <= S_LO; scl_o <= 1'b0;
                end
              end else begin
                if (txm) rxak <= sda_i;
                else     data_r <= sh;
                icf <= 1'b1; iif <= 1'b1; st <= S_HOLD; scl_o <= 1'b0;
              end
            end
          end
          S_P1: begin
            scl_o <= 1'b0; sda_o <= 1'b0;
            if (tick) begin st <= S_P2; scl_o <= 1'b1; end
          end
          S_P2: begin
            if (!scl_i) cnt <= cnt;
            else if (tick) begin st <= S_P3; sda_o <= 1'b1; end
          end
          S_P3: if (tick) st <= S_IDLE;
          S_R1: begin
            scl_o <= 1'b0; sda_o <= 1'b1;
            if (tick) begin st <= S_R2; scl_o <= 1'b1; end
          end
          S_R2: begin
            if (!scl_i) cnt <= cnt;
            else if (tick) begin st <= S_R3; sda_o <= 1'b0; end
          end
          S_R3: if (tick) begin st <= S_LO; scl_o <= 1'b0; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
`timescale 1ns/1ps
module i2c_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_oe,
  input logic sda_oe,
  input logic icf,
  input logic ibb,
  input logic ial,
  input logic iif
);
  AST_OFF_RELEASES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe)); // R10
  AST_OFF_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!icf && !ibb && !ial && !iif)); // R10
  AST_ARB_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ial) |-> iif); // R9
  AST_ARB_RELEASES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ial) |-> (!scl_oe && !sda_oe)); // R9
  AST_DONE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(icf) |-> iif); // R3
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .icf(icf), .ibb(ibb), .ial(ial), .iif(iif)
);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
  localparam int RS = 2;
  localparam int AW = RS + 3;
  localparam logic [8:0] TXV [0:5] = '{
    {8'hA0, 1'b1}, {8'h00, 1'b1}, {8'hFF, 1'b1},
    {8'h5A, 1'b0}, {8'h81, 1'b1}, {8'h3C, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;

  logic [8:0] pat = '0;
  logic hold = 1'b0;
  logic [3:0] idx_drv = '0, bitidx = '0;
  logic slv_low, scl_line, sda_line, pscl = 1'b1, psda = 1'b1;
  logic [7:0] cap = '0;
  logic [8:0] frame = '0;
  int nstart = 0, nstop = 0, nframe = 0, gapc = 0, last_gap = 0, cyc = 0;
  int checks = 0, errors = 0;

  assign slv_low  = (idx_drv < 4'd9) ? pat[4'd8 - idx_drv] : 1'b0;
  assign scl_line = !scl_oe && !hold;
  assign sda_line = !sda_oe && !slv_low;

  always #2.5 clk = ~clk;

  i2c_byte_master #(.REG_SHIFT(RS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(posedge clk) begin
    pscl <= scl_line;
    psda <= sda_line;
    gapc <= gapc + 1;
    if (pscl && scl_line && psda && !sda_line) begin nstart <= nstart + 1; bitidx <= '0; end
    else if (pscl && scl_line && !psda && sda_line) begin nstop <= nstop + 1; bitidx <= '0; end
    if (!pscl && scl_line) begin
      last_gap <= gapc;
      gapc <= 1;
      cap <= {cap[6:0], sda_line};
      if (bitidx == 4'd8) begin
        frame <= {cap, sda_line}; nframe <= nframe + 1; bitidx <= '0;
      end else bitidx <= bitidx + 4'd1;
    end
    if (pscl && !scl_line) idx_drv <= bitidx;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [AW-1:0] a, input logic [7:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(input int i, input logic [7:0] v);
    wr_raw(AW'(i << RS), v);
  endtask

  task automatic rd(input int i, output logic [7:0] v);
    reg_addr = AW'(i << RS); reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_sr(input int b, input logic val, input string tag);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3, s);
      if (s[b] == val) return;
    end
    chk(tag, 0, 1);
  endtask

  task automatic tx_byte(input logic [7:0] b, input logic ack, input string tag);
    logic [7:0] s;
    pat = ack ? 9'h001 : 9'h000;
    wr(3, 8'h00);
    wr(4, b);
    wait_sr(1, 1'b1, tag);
    rd(3, s);
    chk({tag, " frame"}, int'(frame), int'({b, !ack}));
    chk({tag, " rxak"}, int'(s[0]), int'(!ack));
    chk({tag, " complete"}, int'(s[7]), 1);
  endtask

  initial begin
    logic [7:0] v;
    int n0, n1, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      rd(i, v);
      chk("R10 reset register", int'(v), 0);
    end
    chk("R10 reset lines", int'({scl_oe, sda_oe, irq}), 0);

    wr(0, 8'h54);
    wr(1, 8'h01);
    wr(2, 8'hC3);
    rd(0, v); chk("R1 own address", int'(v), 8'h54);
    rd(1, v); chk("R1 divider", int'(v), 8'h01);
    rd(2, v); chk("R1 control", int'(v), 8'hC0);
    wr_raw(AW'((2 << RS) | 1), 8'h00);
    rd(2, v); chk("R1 unaligned write ignored", int'(v), 8'hC0);

    n0 = nstart;
    wr(2, 8'hF0);
    wait_sr(5, 1'b1, "R2 busy after start");
    repeat (8) @(negedge clk);
    chk("R2 start on bus", nstart, n0 + 1);

    for (int k = 0; k < 6; k++)
      tx_byte(TXV[k][8:1], TXV[k][0], "R3 vector");
    chk("R11 irq with pending", int'(irq), 1);
    wr(3, 8'h00);
    chk("R11 irq after clear", int'(irq), 0);

    wr(1, 8'h04);
    tx_byte(8'h33, 1'b1, "R8 slow byte");
    chk("R8 bit period", last_gap, 10);
    wr(1, 8'h01);

    pat = 9'h001;
    wr(3, 8'h00);
    wr(4, 8'h96);
    repeat (3) @(negedge clk);
    while (scl_line) @(negedge clk);
    hold = 1'b1;
    repeat (200) @(negedge clk);
    rd(3, v);
    chk("R8 stretched byte pending", int'(v[1]), 0);
    chk("R7 complete cleared at byte start", int'(v[7]), 0);
    hold = 1'b0;
    wait_sr(1, 1'b1, "R8 stretch end");
    chk("R8 stretched frame", int'(frame), int'({8'h96, 1'b0}));

    n1 = nstart;
    wr(2, 8'hF4);
    tx_byte(8'hA9, 1'b1, "R6 read address");
    chk("R6 repeated start", nstart, n1 + 1);
    rd(2, v); chk("R6 request self-clears", int'(v[2]), 0);

    wr(2, 8'hE0);
    pat = {~8'hC3, 1'b0};
    wr(3, 8'h00);
    rd(4, v);
    wait_sr(1, 1'b1, "R4 first byte");
    chk("R4 acked byte frame", int'(frame), int'({8'hC3, 1'b0}));
    wr(2, 8'hE8);
    pat = {~8'h3E, 1'b0};
    wr(3, 8'h00);
    rd(4, v);
    chk("R4 read returns first byte", int'(v), 8'hC3);
    wait_sr(1, 1'b1, "R4 last byte");
    chk("R4 nacked byte frame", int'(frame), int'({8'h3E, 1'b1}));
    pat = '0;
    f0 = nframe;
    n0 = nstop;
    wr(2, 8'hC0);
    rd(4, v);
    chk("R5 last byte value", int'(v), 8'h3E);
    repeat (40) @(negedge clk);
    chk("R5 no extra byte", nframe, f0);
    chk("R2 stop on bus", nstop, n0 + 1);
    rd(3, v); chk("R2 busy cleared", int'(v[5]), 0);

    wr(2, 8'hF0);
    wait_sr(5, 1'b1, "R9 start");
    repeat (10) @(negedge clk);
    pat = 9'h100;
    wr(3, 8'h00);
    wr(4, 8'hFF);
    wait_sr(1, 1'b1, "R9 arbitration");
    rd(3, v);
    chk("R9 lost flag", int'(v[4]), 1);
    chk("R12 busy held by other device", int'(v[5]), 1);
    rd(2, v); chk("R9 master dropped", int'(v[5]), 0);
    chk("R9 lines released", int'({scl_oe, sda_oe}), 0);
    pat = '0;
    repeat (5) @(negedge clk);
    rd(3, v); chk("R12 busy cleared by foreign stop", int'(v[5]), 0);
    wr(3, 8'h10);
    rd(3, v); chk("R7 keep lost, clear pending", int'(v[4:1]), 4'b1000);
    wr(3, 8'h00);
    rd(3, v); chk("R7 clear lost", int'(v[4]), 0);

    wr(2, 8'hB0);
    wait_sr(5, 1'b1, "R10 start");
    repeat (6) @(negedge clk);
    wr(2, 8'h00);
    @(negedge clk);
    rd(3, v); chk("R10 flags while disabled", int'(v), 0);
    chk("R10 lines while disabled", int'({scl_oe, sda_oe}), 0);
    wr(2, 8'h80);
    repeat (4) @(negedge clk);
    rd(3, v); chk("R10 idle after re-enable", int'(v), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule